// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of a variable-length instruction decoder for the 16/32/64-bit architecture. It takes instruction bytes one per cycle over a valid/ready handshake. It consumes every leading prefix byte, and it stops at the first byte that is not a prefix, which is the opcode. The opcode byte is left on the input and is not consumed, so the next decode stage can take it from the same stream. While it scans, the block gathers the prefix state: the segment override, lock, the operand-size and address-size overrides, the repeat (string) prefix and a REX nibble. From that state and the selected processor mode it derives the effective operand and address widths.

A start strobe opens each instruction. It clears all gathered state and latches the mode. The block then scans until it sees the opcode, or until the instruction has grown to the architectural length limit, which it reports as an error.

Top module: `pfx_scanner`

## Requirements
- R1: Segment override bytes are consumed and set `seg_o` (0x26→1 ES, 0x2E→2 CS, 0x36→3 SS, 0x3E→4 DS, 0x64→5 FS, 0x65→6 GS, 0 = none). A later segment byte replaces an earlier one.
- R2: 0xF0 sets `lock_o`, 0x66 sets `opsz_ovr_o` and 0x67 sets `adsz_ovr_o`. Each is consumed and stays set until the next start.
- R3: 0xF2 and 0xF3 share one register `str_o` (2'b01 = F2, 2'b10 = F3, 2'b00 = none), and the last of them seen wins.
- R4: In 64-bit mode any byte 0x40–0x4F is consumed. Its low nibble appears on `rex_o` with `rex_valid_o` high only when the next byte is the opcode. A legacy prefix after it clears it, and a later REX byte replaces it. Bit 3 of the nibble is W, bit 2 R, bit 1 X and bit 0 B.
- R5: Outside 64-bit mode, bytes 0x40–0x4F are not prefixes: they end the scan as the opcode.
- R6: The opcode byte is never accepted (`byte_ready_o` low while it is presented). One cycle after it is first presented, `done_o` is high for exactly one cycle and `opcode_o` holds it.
- R7: When the count of consumed bytes reaches 15, `error_o` rises and stays high until the next start. No further byte is accepted and `done_o` does not pulse.
- R8: In 64-bit mode `opsize_o` is 64 when a kept REX has W set, else 16 when 0x66 was seen, else 32. Sizes are encoded 2'b00 = 16, 2'b01 = 32, 2'b10 = 64.
- R9: In 64-bit mode `adsize_o` is 32 when 0x67 was seen and 64 otherwise.
- R10: In 32-bit mode 0x66/0x67 make the operand/address size 16 instead of 32. In 16-bit mode they make it 32 instead of 16. `mode_i` is encoded 2'b00 = 16, 2'b01 = 32, 2'b10 = 64, and 2'b11 acts as 32.
- R11: After reset, and in the cycle of a start strobe, no byte is accepted. After reset `done_o` and `error_o` are low and all prefix outputs are zero. A start clears all state gathered for the previous instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-instruction strobe; clears state and latches mode |
| mode_i | input | 2 | Processor mode: 00 = 16, 01 = 32, 10 = 64 |
| byte_valid_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Input instruction byte |
| byte_ready_o | output | 1 | Byte accepted as a prefix this cycle |
| done_o | output | 1 | One-cycle pulse: opcode reached |
| opcode_o | output | 8 | Captured opcode byte |
| error_o | output | 1 | Instruction length limit reached |
| seg_o | output | 3 | Segment override code |
| lock_o | output | 1 | Lock prefix seen |
| opsz_ovr_o | output | 1 | Operand-size override seen |
| adsz_ovr_o | output | 1 | Address-size override seen |
| str_o | output | 2 | Repeat prefix: 01 = F2, 10 = F3 |
| rex_valid_o | output | 1 | REX nibble kept |
| rex_o | output | 4 | Kept REX nibble (W,R,X,B) |
| opsize_o | output | 2 | Effective operand size |
| adsize_o | output | 2 | Effective address size |

## Verification
The hardest situations to reach are those that depend on order. One is a REX byte followed by a legacy prefix, which must be dropped. Another is a legacy prefix followed by a REX byte, which must be kept and change the operand size. The length limit is also hard to reach, because it needs fifteen accepted prefixes, and it has a near miss at fourteen. The stimulus builds byte streams in exactly those orders, in each mode. It sends one stream of fifteen prefixes followed by more bytes, which must stall after the fifteenth. It sends one of fourteen prefixes, which must still finish normally. A scoreboard checks the result of each stream against a model derived from the requirements.

// File: rtl/pfx_scan_pkg.sv
package pfx_scan_pkg;

    typedef enum logic [1:0] {
        SZ16 = 2'b00,
        SZ32 = 2'b01,
        SZ64 = 2'b10
    } size_e;

    typedef enum logic [2:0] {
        SEG_NONE = 3'd0,
        SEG_ES   = 3'd1,
        SEG_CS   = 3'd2,
        SEG_SS   = 3'd3,
        SEG_DS   = 3'd4,
        SEG_FS   = 3'd5,
        SEG_GS   = 3'd6
    } seg_e;

    typedef enum logic [1:0] {
        STR_NONE = 2'b00,
        STR_NE   = 2'b01,
        STR_EQ   = 2'b10
    } str_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2,
        ST_ERR  = 2'd3
    } scan_state_e;

    typedef struct packed {
        logic  is_prefix;
        logic  is_seg;
        seg_e  seg;
        logic  is_lock;
        logic  is_opsz;
        logic  is_adsz;
        logic  is_str;
        str_e  str;
        logic  is_rex;
    } byte_cls_t;

    function automatic size_e decode_mode(input logic [1:0] m);
        case (m)
            2'b00:   return SZ16;
            2'b10:   return SZ64;
            default: return SZ32;
        endcase
    endfunction

endpackage

// File: rtl/pfx_byte_class.sv
module pfx_byte_class
    import pfx_scan_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic       mode64_i,
    output byte_cls_t  cls_o
);

    always_comb begin
        cls_o     = '0;
        cls_o.seg = SEG_NONE;
        cls_o.str = STR_NONE;
        case (byte_i)
            8'h26: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_ES; end
            8'h2E: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_CS; end
            8'h36: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_SS; end
            8'h3E: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_DS; end
            8'h64: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_FS; end
            8'h65: begin cls_o.is_seg = 1'b1; cls_o.seg = SEG_GS; end
            8'hF0: cls_o.is_lock = 1'b1;
            8'h66: cls_o.is_opsz = 1'b1;
            8'h67: cls_o.is_adsz = 1'b1;
            8'hF2: begin cls_o.is_str = 1'b1; cls_o.str = STR_NE; end
            8'hF3: begin cls_o.is_str = 1'b1; cls_o.str = STR_EQ; end
            default: cls_o.is_rex = mode64_i && (byte_i[7:4] == 4'h4);
        endcase
        cls_o.is_prefix = cls_o.is_seg | cls_o.is_lock | cls_o.is_opsz |
                          cls_o.is_adsz | cls_o.is_str | cls_o.is_rex;
    end

endmodule

// File: rtl/pfx_size_resolve.sv
module pfx_size_resolve
    import pfx_scan_pkg::*;
(
    input  size_e       mode_i,
    input  logic        rex_w_i,
    input  logic        opsz_ovr_i,
    input  logic        adsz_ovr_i,
    output logic [1:0]  opsize_o,
    output logic [1:0]  adsize_o
);

    size_e op_s, ad_s;

    always_comb begin
        case (mode_i)
            SZ64: begin
                op_s = rex_w_i ? SZ64 : (opsz_ovr_i ? SZ16 : SZ32);
                ad_s = adsz_ovr_i ? SZ32 : SZ64;
            end
            SZ16: begin
                op_s = opsz_ovr_i ? SZ32 : SZ16;
                ad_s = adsz_ovr_i ? SZ32 : SZ16;
            end
            default: begin
                op_s = opsz_ovr_i ? SZ16 : SZ32;
                ad_s = adsz_ovr_i ? SZ16 : SZ32;
            end
        endcase
        opsize_o = op_s;
        adsize_o = ad_s;
    end

endmodule

// File: rtl/pfx_scanner.sv
module pfx_scanner
    import pfx_scan_pkg::*;
#(
    parameter int MAX_LEN = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    output logic       byte_ready_o,
    output logic       done_o,
    output logic [7:0] opcode_o,
    output logic       error_o,
    output logic [2:0] seg_o,
    output logic       lock_o,
    output logic       opsz_ovr_o,
    output logic       adsz_ovr_o,
    output logic [1:0] str_o,
    output logic       rex_valid_o,
    output logic [3:0] rex_o,
    output logic [1:0] opsize_o,
    output logic [1:0] adsize_o
);

    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_LEN);

    typedef struct packed {
        scan_state_e      st;
        size_e            mode;
        logic [CNT_W-1:0] cnt;
        seg_e             seg;
        logic             lock;
        logic             opsz;
        logic             adsz;
        str_e             str;
        logic             rexv;
        logic [3:0]       rex;
        logic             done;
        logic             error;
        logic [7:0]       opcode;
    } scan_t;

    localparam scan_t SCAN_RST = '{st: ST_IDLE, mode: SZ16, seg: SEG_NONE,
                                    str: STR_NONE, default: '0};

    scan_t     s_d, s_q;
    byte_cls_t cls;

    pfx_byte_class u_class (
        .byte_i   (byte_i),
        .mode64_i (s_q.mode == SZ64),
        .cls_o    (cls)
    );

    pfx_size_resolve u_size (
        .mode_i     (s_q.mode),
        .rex_w_i    (s_q.rexv & s_q.rex[3]),
        .opsz_ovr_i (s_q.opsz),
        .adsz_ovr_i (s_q.adsz),
        .opsize_o   (opsize_o),
        .adsize_o   (adsize_o)
    );

    assign byte_ready_o = !start_i && (s_q.st == ST_SCAN) && cls.is_prefix;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start_i) begin
            s_d      = SCAN_RST;
            s_d.st   = ST_SCAN;
            s_d.mode = decode_mode(mode_i);
        end else if (s_q.st == ST_SCAN && byte_valid_i) begin
            if (cls.is_prefix) begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (cls.is_seg)  s_d.seg  = cls.seg;
                if (cls.is_lock) s_d.lock = 1'b1;
                if (cls.is_opsz) s_d.opsz = 1'b1;
                if (cls.is_adsz) s_d.adsz = 1'b1;
                if (cls.is_str)  s_d.str  = cls.str;
                if (cls.is_rex) begin
                    s_d.rexv = 1'b1;
                    s_d.rex  = byte_i[3:0];
                end else begin
                    s_d.rexv = 1'b0;
                    s_d.rex  = 4'h0;
                end
                if (s_d.cnt == CNT_LIMIT) begin
                    s_d.st    = ST_ERR;
                    s_d.error = 1'b1;
                end
            end else begin
                s_d.st     = ST_HOLD;
                s_d.done   = 1'b1;
                s_d.opcode = byte_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SCAN_RST;
        else        s_q <= s_d;
    end

    assign done_o      = s_q.done;
    assign opcode_o    = s_q.opcode;
    assign error_o     = s_q.error;
    assign seg_o       = s_q.seg;
    assign lock_o      = s_q.lock;
    assign opsz_ovr_o  = s_q.opsz;
    assign adsz_ovr_o  = s_q.adsz;
    assign str_o       = s_q.str;
    assign rex_valid_o = s_q.rexv;
    assign rex_o       = s_q.rex;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done held"); // R6
    AST_NO_DONE_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !error_o) else $error("done with error"); // R7
    AST_ERR_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> !byte_ready_o) else $error("accept after error"); // R7
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_LIMIT) else $error("count overrun"); // R7
    AST_REX_ONLY_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        rex_valid_o |-> (s_q.mode == SZ64)) else $error("rex outside 64"); // R4
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (opsize_o != 2'b11) && (adsize_o != 2'b11)) else $error("bad size"); // R8
    AST_START_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !byte_ready_o) else $error("accept on start"); // R11

endmodule

// File: tb/pfx_scanner_tb.sv
`timescale 1ns/1ps
module pfx_scanner_tb_top;

    localparam time CLK_P = 20ns;
    localparam logic [1:0] M16 = 2'b00, M32 = 2'b01, M64 = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = M32;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       byte_ready_o, done_o, error_o, lock_o, opsz_ovr_o, adsz_ovr_o, rex_valid_o;
    logic [7:0] opcode_o;
    logic [2:0] seg_o;
    logic [1:0] str_o, opsize_o, adsize_o;
    logic [3:0] rex_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    pfx_scanner dut_i (.*);

    typedef struct {
        logic       err;
        int         consumed;
        logic [7:0] opc;
        logic [2:0] seg;
        logic       lock, opsz, adsz, rexv;
        logic [1:0] str, osz, asz;
        logic [3:0] rex;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [1:0] m, input logic [7:0] b[$]);
        exp_t e;
        bit l64 = (m == M64);
        e = '{err: 0, consumed: 0, opc: 0, seg: 0, lock: 0, opsz: 0, adsz: 0,
              rexv: 0, str: 0, osz: 0, asz: 0, rex: 0};
        foreach (b[i]) begin
            logic [7:0] x = b[i];
            bit pre = 1'b1;
            case (x)
                8'h26: e.seg = 1; 8'h2E: e.seg = 2; 8'h36: e.seg = 3;
                8'h3E: e.seg = 4; 8'h64: e.seg = 5; 8'h65: e.seg = 6;
                8'hF0: e.lock = 1; 8'h66: e.opsz = 1; 8'h67: e.adsz = 1;
                8'hF2: e.str = 2'b01; 8'hF3: e.str = 2'b10;
                default: pre = l64 && (x[7:4] == 4'h4);
            endcase
            if (!pre) begin e.opc = x; break; end
            if (l64 && x[7:4] == 4'h4) begin e.rexv = 1; e.rex = x[3:0]; end
            else begin e.rexv = 0; e.rex = 0; end
            e.consumed++;
            if (e.consumed == 15) begin e.err = 1; break; end
        end
        if (l64) begin
            e.osz = (e.rexv && e.rex[3]) ? 2'b10 : (e.opsz ? 2'b00 : 2'b01);
            e.asz = e.adsz ? 2'b01 : 2'b10;
        end else if (m == M16) begin
            e.osz = e.opsz ? 2'b01 : 2'b00;
            e.asz = e.adsz ? 2'b01 : 2'b00;
        end else begin
            e.osz = e.opsz ? 2'b00 : 2'b01;
            e.asz = e.adsz ? 2'b00 : 2'b01;
        end
        return e;
    endfunction

    task automatic run_insn(input logic [1:0] m, input logic [7:0] b[$]);
        exp_t e = model(m, b);
        int n = 0;
        exp_q.push_back(e);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; byte_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < b.size(); i++) begin
            byte_i = b[i]; byte_valid_i = 1'b1;
            #1;
            if (!byte_ready_o) break;
            n++;
            @(negedge clk);
        end
        // R6: opcode (and anything after an error) is left unconsumed
        check(n == e.consumed, "R6/R7 consumed count", n, e.consumed);
        @(negedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R6 done single pulse", done_o, 0);
        byte_valid_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Scoreboard monitor
    initial begin
        logic prev_err = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (done_o || (error_o && !prev_err))) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected event", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(error_o == e.err, "R7 error flag", error_o, e.err);
                    check(done_o == !e.err, "R6 done vs error", done_o, !e.err);
                    if (!e.err) begin
                        check(opcode_o == e.opc, "R6 opcode", opcode_o, e.opc);
                        check(seg_o == e.seg, "R1 segment", seg_o, e.seg);
                        check(lock_o == e.lock, "R2 lock", lock_o, e.lock);
                        check(opsz_ovr_o == e.opsz, "R2 opsz", opsz_ovr_o, e.opsz);
                        check(adsz_ovr_o == e.adsz, "R2 adsz", adsz_ovr_o, e.adsz);
                        check(str_o == e.str, "R3 string", str_o, e.str);
                        check(rex_valid_o == e.rexv, "R4 rex valid", rex_valid_o, e.rexv);
                        check(rex_o == e.rex, "R4 rex nibble", rex_o, e.rex);
                        check(opsize_o == e.osz, "R8/R10 opsize", opsize_o, e.osz);
                        check(adsize_o == e.asz, "R9/R10 adsize", adsize_o, e.asz);
                    end
                end
            end
            prev_err = error_o;
        end
    end

    // Watchdog
    initial begin
        #(CLK_P * 100000);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        byte_valid_i = 1'b1; byte_i = 8'h66;
        #1;
        // R11: reset state
        check(byte_ready_o == 1'b0, "R11 ready after reset", byte_ready_o, 0);
        check(done_o == 1'b0 && error_o == 1'b0, "R11 done/error after reset", {done_o, error_o}, 0);
        check(seg_o == 0 && str_o == 0 && !rex_valid_o && !lock_o, "R11 flags after reset",
              {seg_o, str_o, rex_valid_o, lock_o}, 0);
        byte_valid_i = 1'b0;

        // R1 R2 R3 R10: 32-bit mixed legacy prefixes, last seg/string wins
        q = '{8'h2E, 8'h36, 8'hF0, 8'h66, 8'hF3, 8'hF2, 8'h89}; run_insn(M32, q);
        // R11: start clears previous flags
        q = '{8'h90}; run_insn(M32, q);
        // R5: 0x48 is the opcode in 32-bit mode
        q = '{8'h67, 8'h48}; run_insn(M32, q);
        // R5: 0x40 opcode in 16-bit mode
        q = '{8'h40, 8'h66}; run_insn(M16, q);
        // R4 R8: legacy then REX.W kept
        q = '{8'h66, 8'h48, 8'h8B}; run_insn(M64, q);
        // R4: REX followed by legacy is discarded
        q = '{8'h48, 8'h66, 8'h8B}; run_insn(M64, q);
        // R4: later REX replaces earlier
        q = '{8'h41, 8'h4C, 8'h01}; run_insn(M64, q);
        // R9 R1: 64-bit address override, GS
        q = '{8'h67, 8'h65, 8'hC3}; run_insn(M64, q);
        // R10: 16-bit mode overrides widen
        q = '{8'h66, 8'h67, 8'h26, 8'h90}; run_insn(M16, q);
        // R3 R1: F3 wins, CS last, FS/DS earlier
        q = '{8'hF2, 8'h3E, 8'h64, 8'hF3, 8'h2E, 8'hA4}; run_insn(M64, q);
        // R10: mode 11 acts as 32-bit
        q = '{8'h66, 8'h44, 8'h00}; run_insn(2'b11, q);
        // R7: fifteen prefixes -> error
        q = {};
        for (int i = 0; i < 15; i++) q.push_back((i % 2) ? 8'h66 : 8'hF0);
        q.push_back(8'h66); q.push_back(8'h90);
        run_insn(M64, q);
        check(error_o == 1'b1, "R7 error sticky", error_o, 1);
        // R7: fourteen prefixes still complete, ending with kept REX
        q = {};
        for (int i = 0; i < 13; i++) q.push_back(8'h26);
        q.push_back(8'h4F); q.push_back(8'h0F);
        run_insn(M64, q);
        // R11: start clears error
        check(error_o == 1'b0, "R11 error cleared", error_o, 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule